// File: doc/BRIEF.md
# Touch-Panel ADC Scan Sequencer

The block runs a complete scan of an 8-channel, 12-bit touch-panel converter over a mode-0 SPI link. A start pulse latches an 8-bit channel-enable mask. The block then visits the enabled channels from the lowest index upward. For each channel it issues a group of 24-bit frames. Each frame is a command byte followed by a 16-bit big-endian response. Every command byte is built inside the block from the channel address, the reference selection and the position of the frame within its group.

Each channel has two configuration fields, a skip count and an oversampling ratio. A group holds skip + ratio frames. The first skip responses are settling conversions and are thrown away. The 12-bit results of the remaining frames are summed, and the sum is divided by the ratio with rounding up. The averaged value of the k-th enabled channel lands in result slot k. Once every group has finished, a one-cycle done pulse marks the result file as valid. Chip select stays low from the first frame of a scan to the last.

Top module: `touch_scan_seq`

## Requirements
- R1: While reset is held and right after it, cs_no is 1, sclk_o is 0, busy_o and done_o are 0, and every result slot is zero.
- R2: Every command byte has bit 7 = 1, the channel address (0..7) in bits 6:4 and bit 3 = 0.
- R3: For channels 0, 2, 6 and 7, bit 2 (single-ended) is 1 and bit 1 (reference on) equals int_vref_i. For channels 1, 3, 4 and 5, bits 2 and 1 are both 0.
- R4: Bit 0 (converter kept on) is 1 in every frame of a group except the last one, where it is 0.
- R5: A frame is 24 SCLK periods with the MSB first. SCLK idles low. MOSI changes after a falling edge and MISO is sampled on the rising edge. The command occupies the first 8 bits. cs_no stays 0 across all frames of a scan, including the gaps between groups, and is 1 whenever busy_o is 0.
- R6: Enabled channels are scanned in ascending order. Each channel's group holds skip + n frames, where n is its ratio field and a field value of 0 counts as n = 1.
- R7: Only response bits 14:3 form the result; bits 15 and 2:0 are ignored. The first skip results of a group are discarded, and the group value is ceil(sum / n) of the rest.
- R8: Result slot k, at bits 12k+11:12k of result_o, holds the value of the k-th enabled channel in ascending order.
- R9: done_o is a single-cycle pulse, raised exactly T*(48*CLK_DIV+1)+G cycles after the edge that accepts start, where T is the total number of frames and G the number of enabled channels. busy_o is 0 while done_o is 1.
- R10: A start with an all-zero mask raises done_o in the cycle after the start edge, and the scan produces no SCLK activity and no chip-select assertion.
- R11: A start_i pulse while busy_o is 1 is ignored. The frame sequence, the results and the done timing are those of the original scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a scan when idle |
| ch_mask_i | input | 8 | Channel enable mask, sampled at start |
| int_vref_i | input | 1 | Internal reference selected |
| skip_cfg_i | input | 8*SKIP_W | Per-channel settling-frame count, channel c at bits SKIP_W*c upward |
| ovs_cfg_i | input | 8*OVS_W | Per-channel oversampling ratio, 0 treated as 1 |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse when results are valid |
| result_o | output | 96 | Eight 12-bit averaged results, slot k at bits 12k upward |
| sclk_o | output | 1 | SPI clock, idles low |
| mosi_o | output | 1 | SPI data to the converter |
| miso_i | input | 1 | SPI data from the converter |
| cs_no | output | 1 | Active-low chip select |

## Verification
A frame needs 48*CLK_DIV cycles of SCLK toggling plus one cycle for the sequencer to take up the response. Entering each group costs one more cycle. The done pulse is therefore due exactly T*(48*CLK_DIV+1)+G cycles after the start edge, or zero cycles after it for an empty mask. The bench derives T and G from the mask and the per-channel configuration, counts rising edges after start, and requires done at exactly that count. It samples results, command bytes and chip select only on the falling clock edge or when a frame's 24th SCLK rise completes.

// File: rtl/touch_scan_pkg.sv
package touch_scan_pkg;
  localparam int unsigned NUM_CH     = 8;
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned RES_W      = 12;
  localparam int unsigned CMD_BITS   = 8;
  localparam int unsigned RESP_BITS  = 16;
  localparam int unsigned FRAME_BITS = CMD_BITS + RESP_BITS;

  typedef enum logic [1:0] {ST_IDLE, ST_GROUP, ST_FRAME} seq_state_e;

  // lowest set index; loop runs high to low so the lowest wins
  function automatic logic [ADDR_W-1:0] lowest_set(input logic [NUM_CH-1:0] m);
    logic [ADDR_W-1:0] idx;
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (m[i]) idx = ADDR_W'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/tsc_cmd_enc.sv
module tsc_cmd_enc
  import touch_scan_pkg::*;
(
  input  logic [ADDR_W-1:0]   ch_i,
  input  logic                int_vref_i,
  input  logic                keep_on_i,
  output logic [CMD_BITS-1:0] cmd_o
);
  logic single_ended;

  always_comb begin
    unique case (ch_i)
      3'd0, 3'd2, 3'd6, 3'd7: single_ended = 1'b1;
      default:                single_ended = 1'b0;
    endcase
  end

  assign cmd_o = {1'b1, ch_i, 1'b0, single_ended, single_ended & int_vref_i, keep_on_i};
endmodule

// File: rtl/tsc_spi_frame.sv
module tsc_spi_frame
  import touch_scan_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [CMD_BITS-1:0]  cmd_i,
  input  logic                 miso_i,
  output logic                 sclk_o,
  output logic                 mosi_o,
  output logic                 done_o,
  output logic [RESP_BITS-1:0] resp_o
);
  localparam int unsigned DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int unsigned BIT_W = $clog2(FRAME_BITS);

  logic                  run_q, sclk_q, done_q;
  logic [DIV_W-1:0]      div_q;
  logic [BIT_W-1:0]      bit_q;
  logic [FRAME_BITS-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        run_q  <= 1'b1;
        sclk_q <= 1'b0;
        div_q  <= '0;
        bit_q  <= '0;
        tx_q   <= {cmd_i, {RESP_BITS{1'b0}}};
      end else if (run_q) begin
        if (div_q == DIV_W'(CLK_DIV - 1)) begin
          div_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[FRAME_BITS-2:0], miso_i};
          end else begin
            sclk_q <= 1'b0;
            tx_q   <= {tx_q[FRAME_BITS-2:0], 1'b0};
            if (bit_q == BIT_W'(FRAME_BITS - 1)) begin
              run_q  <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[FRAME_BITS-1];
  assign done_o = done_q;
  assign resp_o = rx_q[RESP_BITS-1:0];

  logic unused_rx;
  assign unused_rx = ^rx_q[FRAME_BITS-1:RESP_BITS];

  assert_no_overlap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !run_q);
  assert_sclk_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !sclk_q);
endmodule

// File: rtl/tsc_avg_div.sv
module tsc_avg_div #(
  parameter int unsigned SUM_W = 16,
  parameter int unsigned N_W   = 4
) (
  input  logic [SUM_W-1:0] sum_i,
  input  logic [N_W-1:0]   n_i,
  output logic [SUM_W-1:0] avg_o
);
  logic [SUM_W:0] biased;
  logic [SUM_W:0] quot;

  // caller guarantees n_i != 0
  assign biased = {1'b0, sum_i} + (SUM_W+1)'(n_i) - 1'b1;
  assign quot   = biased / (SUM_W+1)'(n_i);
  assign avg_o  = quot[SUM_W-1:0];

  logic unused_quot;
  assign unused_quot = quot[SUM_W];
endmodule

// File: rtl/touch_scan_seq.sv
module touch_scan_seq
  import touch_scan_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned SKIP_W  = 4,
  parameter int unsigned OVS_W   = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [NUM_CH-1:0]       ch_mask_i,
  input  logic                    int_vref_i,
  input  logic [NUM_CH*SKIP_W-1:0] skip_cfg_i,
  input  logic [NUM_CH*OVS_W-1:0]  ovs_cfg_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [NUM_CH*RES_W-1:0] result_o,
  output logic                    sclk_o,
  output logic                    mosi_o,
  input  logic                    miso_i,
  output logic                    cs_no
);
  localparam int unsigned CNT_W = ((SKIP_W > OVS_W) ? SKIP_W : OVS_W) + 1;
  localparam int unsigned SUM_W = RES_W + OVS_W;
  localparam int unsigned SLOT_W = $clog2(NUM_CH);

  seq_state_e          state_q;
  logic [NUM_CH-1:0]   mask_q;
  logic [ADDR_W-1:0]   ch_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [CNT_W-1:0]    frm_q;
  logic [SUM_W-1:0]    acc_q;
  logic [RES_W-1:0]    res_q [NUM_CH];
  logic                done_q, cs_q;

  logic [SKIP_W-1:0]   skip_arr [NUM_CH];
  logic [OVS_W-1:0]    ovs_arr  [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
    assign skip_arr[c] = skip_cfg_i[c*SKIP_W +: SKIP_W];
    assign ovs_arr[c]  = ovs_cfg_i[c*OVS_W +: OVS_W];
    assign result_o[c*RES_W +: RES_W] = res_q[c];
  end

  logic [ADDR_W-1:0]    ch_sel;
  logic [SKIP_W-1:0]    cur_skip;
  logic [OVS_W-1:0]     cur_n;
  logic [CNT_W-1:0]     total, load_idx;
  logic                 cur_last, next_last, frame_start;
  logic                 frm_done;
  logic [RESP_BITS-1:0] resp;
  logic [RES_W-1:0]     sample;
  logic [SUM_W-1:0]     acc_nxt, avg;
  logic [CMD_BITS-1:0]  cmd;
  logic [NUM_CH-1:0]    mask_rest;

  assign ch_sel    = (state_q == ST_GROUP) ? lowest_set(mask_q) : ch_q;
  assign cur_skip  = skip_arr[ch_sel];
  assign cur_n     = (ovs_arr[ch_sel] == '0) ? OVS_W'(1) : ovs_arr[ch_sel];
  assign total     = CNT_W'(cur_skip) + CNT_W'(cur_n);
  assign load_idx  = (state_q == ST_GROUP) ? '0 : frm_q + 1'b1;
  assign cur_last  = (frm_q == total - 1'b1);
  assign next_last = (load_idx == total - 1'b1);
  assign frame_start = (state_q == ST_GROUP) ||
                       (state_q == ST_FRAME && frm_done && !cur_last);

  // result field lives in bits 14:3 of the response word
  assign sample    = resp[RES_W+2:3];
  assign acc_nxt   = acc_q + ((frm_q >= CNT_W'(cur_skip)) ? SUM_W'(sample) : '0);
  assign mask_rest = mask_q & ~(NUM_CH'(1) << ch_q);

  logic unused_resp;
  assign unused_resp = ^{resp[RESP_BITS-1], resp[2:0], avg[SUM_W-1:RES_W]};

  tsc_cmd_enc u_cmd (
    .ch_i      (ch_sel),
    .int_vref_i(int_vref_i),
    .keep_on_i (!next_last),
    .cmd_o     (cmd)
  );

  tsc_spi_frame #(.CLK_DIV(CLK_DIV)) u_frame (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(frame_start),
    .cmd_i (cmd),
    .miso_i(miso_i),
    .sclk_o(sclk_o),
    .mosi_o(mosi_o),
    .done_o(frm_done),
    .resp_o(resp)
  );

  tsc_avg_div #(.SUM_W(SUM_W), .N_W(OVS_W)) u_avg (
    .sum_i(acc_nxt),
    .n_i  (cur_n),
    .avg_o(avg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      ch_q    <= '0;
      slot_q  <= '0;
      frm_q   <= '0;
      acc_q   <= '0;
      done_q  <= 1'b0;
      cs_q    <= 1'b1;
      for (int i = 0; i < NUM_CH; i++) res_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (ch_mask_i == '0) begin
              done_q <= 1'b1;
            end else begin
              mask_q  <= ch_mask_i;
              slot_q  <= '0;
              state_q <= ST_GROUP;
            end
          end
        end
        ST_GROUP: begin
          ch_q    <= ch_sel;
          frm_q   <= '0;
          acc_q   <= '0;
          cs_q    <= 1'b0;
          state_q <= ST_FRAME;
        end
        ST_FRAME: begin
          if (frm_done) begin
            acc_q <= acc_nxt;
            if (cur_last) begin
              res_q[slot_q] <= avg[RES_W-1:0];
              slot_q <= slot_q + 1'b1;
              mask_q <= mask_rest;
              if (mask_rest == '0) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
                cs_q    <= 1'b1;
              end else begin
                state_q <= ST_GROUP;
              end
            end else begin
              frm_q <= frm_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign cs_no  = cs_q;

  assert_cs_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);
  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_start_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ((mask_q & ~$past(mask_q)) == '0));
  assert_group_enabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GROUP) |-> (mask_q != '0));
  assert_mask_drained_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mask_q == '0));
endmodule

// File: tb/touch_scan_seq_bench.sv
module touch_scan_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int D      = 1;
  localparam int SKIP_W = 2;
  localparam int OVS_W  = 2;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, vref = 1'b0;
  logic [7:0] mask = '0;
  logic [8*SKIP_W-1:0] skip_cfg;
  logic [8*OVS_W-1:0]  ovs_cfg;
  logic busy, done, sclk, mosi, miso, cs_n;
  logic [95:0] result;

  always #(CLK_PERIOD/2) clk = ~clk;

  touch_scan_seq #(.CLK_DIV(D), .SKIP_W(SKIP_W), .OVS_W(OVS_W)) u_touch_scan_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ch_mask_i(mask),
    .int_vref_i(vref), .skip_cfg_i(skip_cfg), .ovs_cfg_i(ovs_cfg),
    .busy_o(busy), .done_o(done), .result_o(result),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  int tests = 0, fails = 0;
  int skip_c [8];
  int ovs_c  [8];
  int seed = 0;
  bit all_max = 1'b0;
  int fr_idx = 0, fr_base = 0;
  logic [7:0] exp_cmd [64];
  int exp_res [8];
  int exp_t, exp_g;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int data_of(input int fr);
    if (all_max) return 4095;
    return (fr * 1237 + seed * 311 + 2049) % 4096;
  endfunction

  // bits 15 and 2:0 carry junk that must be ignored (R7)
  function automatic logic [15:0] word_of(input int fr);
    logic [11:0] d;
    d = 12'(data_of(fr));
    return {1'b1, d, 3'b101};
  endfunction

  // converter model
  logic [4:0]  bc = '0;
  logic [7:0]  cap = '0, cmd_seen = '0;
  logic [15:0] cur_word;
  assign cur_word = word_of(fr_idx);
  assign miso = (bc >= 5'd8) ? cur_word[5'd23 - bc] : 1'b0;

  always @(posedge sclk) begin
    int rel;
    cap = {cap[6:0], mosi};
    bc  = bc + 5'd1;
    if (bc == 5'd8) cmd_seen = cap;
    if (bc == 5'd24) begin
      rel = fr_idx - fr_base;
      chk(cs_n == 1'b0, "R5 cs low during frame", int'(cs_n), 0);
      if (rel < 64)
        chk(cmd_seen == exp_cmd[rel], "R2 R3 R4 command byte", int'(cmd_seen), int'(exp_cmd[rel]));
      else
        chk(1'b0, "R6 frame count overrun", rel, 63);
      fr_idx++;
      bc = '0;
    end
  end

  task automatic apply_cfg();
    for (int c = 0; c < 8; c++) begin
      skip_cfg[c*SKIP_W +: SKIP_W] = SKIP_W'(skip_c[c]);
      ovs_cfg[c*OVS_W +: OVS_W]    = OVS_W'(ovs_c[c]);
    end
  endtask

  task automatic build_expect(input logic [7:0] m, input bit vr);
    int i, slot, n, sum;
    logic se;
    i = 0; slot = 0; exp_g = 0;
    for (int ch = 0; ch < 8; ch++) begin
      if (m[ch]) begin
        exp_g++;
        n = (ovs_c[ch] == 0) ? 1 : ovs_c[ch];
        sum = 0;
        se = (ch == 0 || ch == 2 || ch == 6 || ch == 7);
        for (int f = 0; f < skip_c[ch] + n; f++) begin
          exp_cmd[i] = {1'b1, 3'(ch), 1'b0, se, se & vr, (f != skip_c[ch] + n - 1)};
          if (f >= skip_c[ch]) sum += data_of(fr_base + i);
          i++;
        end
        exp_res[slot] = (sum + n - 1) / n;
        slot++;
      end
    end
    exp_t = i;
  endtask

  task automatic run_scan(input logic [7:0] m, input bit vr, input bit inject);
    int cnt, k;
    @(negedge clk);
    fr_base = fr_idx;
    vref = vr;
    build_expect(m, vr);
    k = exp_t * (48 * D + 1) + exp_g;
    mask = m;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (inject) mask = ~m;
    cnt = 0;
    while (!done && cnt < 20000) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (inject) start = (cnt == 5);
    end
    start = 1'b0;
    chk(cnt == k, m == 0 ? "R10 done latency empty mask" : (inject ? "R11 done latency with start while busy" : "R9 done latency"), cnt, k);
    chk(busy == 1'b0, "R9 busy low at done", int'(busy), 0);
    chk(fr_idx - fr_base == exp_t, m == 0 ? "R10 no frames" : "R6 frame count", fr_idx - fr_base, exp_t);
    for (int s = 0; s < exp_g; s++)
      chk(int'(result[s*12 +: 12]) == exp_res[s], "R7 R8 averaged slot value", int'(result[s*12 +: 12]), exp_res[s]);
    if (m == 0) chk(cs_n == 1'b1 && sclk == 1'b0, "R10 no chip select", int'(cs_n), 1);
    @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
    chk(cs_n == 1'b1, "R5 cs released after scan", int'(cs_n), 1);
    mask = m;
  endtask

  initial begin
    for (int c = 0; c < 8; c++) begin skip_c[c] = 0; ovs_c[c] = 1; end
    apply_cfg();
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs idle in reset", int'(cs_n), 1);
    chk(sclk == 1'b0, "R1 sclk low in reset", int'(sclk), 0);
    chk(busy == 1'b0 && done == 1'b0, "R1 busy/done low in reset", int'({busy, done}), 0);
    chk(result == '0, "R1 results zero in reset", int'(result[11:0]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1 && busy == 1'b0, "R1 idle after reset", int'(cs_n), 1);

    // every mask with one frame per group
    for (int m = 0; m < 256; m++) begin
      seed = m;
      run_scan(8'(m), m[0], m == 8'hA5);
    end

    // internal reference on all channels
    seed = 300;
    run_scan(8'hFF, 1'b1, 1'b0);

    // skip and ratio sweep, per-channel mix
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 4; o++) begin
        for (int c = 0; c < 8; c++) begin
          skip_c[c] = (c + s) % 4;
          ovs_c[c]  = (c + o) % 4;
        end
        apply_cfg();
        seed = 400 + s * 4 + o;
        run_scan((s + o) % 2 == 0 ? 8'hFF : 8'b1100_0101, o[0], s == 2 && o == 1);
      end
    end

    // full-scale data with maximum oversampling
    for (int c = 0; c < 8; c++) begin skip_c[c] = 1; ovs_c[c] = 3; end
    apply_cfg();
    all_max = 1'b1;
    run_scan(8'hFF, 1'b0, 1'b0);
    all_max = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk(1'b0, "R9 watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule